// File: doc/BRIEF.md
# NAND Page Program Sequencer

The sequencer carries out one page program on a NAND flash device. The flash has a byte-wide bus on which a command strobe and an address strobe qualify each written byte. A single `start` pulse captures the target block, the page within that block, the address mode and the status-command flavour. The sequencer then drives chip enable low and writes the program-setup command. It follows with the column address bytes and then the three row address bytes. Next it moves the main-area bytes and then the spare-area bytes from a valid/ready byte stream onto the bus, and writes the confirm command.

After the confirm command the block waits for the device's ready/busy line to go low and then come back high. It then writes a status-read command and keeps reading status until the ready bit is set, and the fail bit of that final status becomes the program-fail flag. If the busy wait runs past a programmable cycle limit, the operation ends with a timeout flag and no status read is made. The ECC itself is computed elsewhere. This block raises `ecc_en` only while main-area bytes are being moved, so that an external ECC engine can take exactly those bytes and no spare byte.

Top module: `nand_prog_seq`

## Requirements
- R1: When a `start` is accepted in idle, `nf_ce_n` goes low. The first bus write is command 0x80 (`nf_cle`=1, `nf_ale`=0). `nf_ce_n` stays low through every later bus write and read of the operation.
- R2: After 0x80, the block writes address bytes of value 0x00 (`nf_ale`=1): one byte when `five_cyc_i`=0, two bytes when `five_cyc_i`=1.
- R3: Three more address bytes follow, least significant first. They carry row = (block_i << PPB_LOG2) + page_i.
- R4: Next come exactly PAGE_BYTES main bytes and then SPARE_BYTES spare bytes, written with `nf_cle`=`nf_ale`=0. They appear in stream order, and a byte is written only in a cycle where `s_valid` and `s_ready` are both 1. `s_ready` is 1 only during these two data phases.
- R5: `ecc_en` is 1 on every main-byte write and is 0 on every spare byte, every command and every address byte.
- R6: Command 0x10 is written right after the last spare byte.
- R7: The status command is 0x70 when `multi_plane_i`=0 and 0x71 when it is 1. It is written only after the two-flop-synchronized `nf_rb` has been seen low after the confirm command and then seen high. It goes out 4 cycles after `nf_rb` returns high.
- R8: After the status command, the block pulses `nf_rd` once per cycle and samples `nf_dq_i` in each such cycle, until bit 6 of `nf_dq_i` is 1. Bit 0 of that last status becomes `err_fail`. Bit 0 of a status without bit 6 is ignored.
- R9: The cycle count in the busy wait starts at 0 on the cycle after the confirm command. If this count reaches `timeout_i` without the low-then-high return of `nf_rb`, the operation ends with `err_tmo`=1 and `err_fail`=0, and no status command is written. `done` is then high timeout_i+2 cycles after the confirm write.
- R10: Every operation ends with `done` high for exactly one cycle, during which `nf_ce_n` is already 1. `err_fail` and `err_tmo` keep their values after `done` until the next accepted `start`, which clears both.
- R11: A `start`, or a change of `block_i` or `page_i`, while an operation is under way has no effect on that operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one page program (taken only in idle) |
| block_i | input | BLK_W | Target block |
| page_i | input | PAGE_W | Page within the block |
| five_cyc_i | input | 1 | 1: two column bytes (five address cycles) |
| multi_plane_i | input | 1 | 1: use 0x71 as the status command |
| timeout_i | input | TMO_W | Busy-wait limit in cycles |
| s_valid | input | 1 | Stream byte available |
| s_data | input | 8 | Stream byte |
| s_ready | output | 1 | Sequencer accepts a stream byte |
| nf_ce_n | output | 1 | Flash chip enable, active low |
| nf_cle | output | 1 | Written byte is a command |
| nf_ale | output | 1 | Written byte is an address |
| nf_wr | output | 1 | Bus write strobe: `nf_dq_o` valid this cycle |
| nf_rd | output | 1 | Bus read strobe: `nf_dq_i` sampled this cycle |
| nf_dq_o | output | 8 | Byte to the flash |
| nf_dq_i | input | 8 | Byte from the flash (status) |
| nf_rb | input | 1 | Flash ready/busy, asynchronous, 0 = busy |
| ecc_en | output | 1 | Main-area ECC capture window |
| done | output | 1 | One-cycle completion pulse |
| err_fail | output | 1 | Program failed (status bit 0) |
| err_tmo | output | 1 | Busy wait timed out |

## Verification
The bench builds the sequencer with a 16-byte main area, a 4-byte spare area, 32 pages per block and a 10-bit block field. With these sizes a full operation, from setup command to status, takes a few dozen cycles. Each operation's bus log can then be compared byte by byte, with its ECC flag, in both address modes and for every row byte. The 12-bit timeout port allows short limits, so a flash that never goes busy and a flash that stays busy both reach the timeout path, and the exact cycle of `done` can be checked there.

// File: rtl/nps_pkg.sv
// Shared types and command codes for the NAND page program sequencer.
// Assumes an 8-bit flash bus and a three-byte row address.
package nps_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SETUP,
        ST_COL,
        ST_ROW,
        ST_MAIN,
        ST_SPARE,
        ST_CONF,
        ST_WAIT,
        ST_STAT,
        ST_POLL,
        ST_END
    } nps_state_e;

    localparam logic [7:0] CMD_PROG_SETUP = 8'h80;
    localparam logic [7:0] CMD_PROG_CONF  = 8'h10;
    localparam logic [7:0] CMD_STATUS     = 8'h70;
    localparam logic [7:0] CMD_STATUS_MP  = 8'h71;

    localparam int ROW_BYTES     = 3;
    localparam int STAT_RDY_BIT  = 6;
    localparam int STAT_FAIL_BIT = 0;

endpackage

// File: rtl/nps_rb_sync.sv
// Ready/busy tracker: brings the asynchronous flash ready/busy line in
// through two flops. After being armed, it reports a completed busy
// phase only once the synchronized line has been low and is high again.
// Assumes the line idles high (ready).
module nps_rb_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic rb_i,
    input  logic arm_i,
    output logic done_o
);
    logic [1:0] sync_q;
    logic       seen_low_q;
    logic       rb_s;

    // two-flop synchronizer, reset to the ready level
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rb_i};
    end

    assign rb_s = sync_q[1];

    // remember a low phase seen since the last arm
    always_ff @(posedge clk) begin
        if (!rst_n)     seen_low_q <= 1'b0;
        else if (arm_i) seen_low_q <= 1'b0;
        else if (!rb_s) seen_low_q <= 1'b1;
    end

    assign done_o = seen_low_q & rb_s;
endmodule

// File: rtl/nps_busy_timer.sv
// Busy-wait timer: counts the cycles spent waiting and flags expiry
// once the count reaches the limit. Saturates instead of wrapping.
module nps_busy_timer #(
    parameter int W = 20
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr_i,
    input  logic         run_i,
    input  logic [W-1:0] limit_i,
    output logic         expired_o
);
    localparam logic [W-1:0] CNT_MAX = '1;

    logic [W-1:0] cnt_q;

    // cycle counter for the wait phase
    always_ff @(posedge clk) begin
        if (!rst_n)                        cnt_q <= '0;
        else if (clr_i)                    cnt_q <= '0;
        else if (run_i && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && (cnt_q >= limit_i);
endmodule

// File: rtl/nps_row_addr.sv
// Row address builder: forms row = (block << PPB_LOG2) + page and
// selects one of its bytes, byte 0 being least significant.
// Assumes BLK_W + PPB_LOG2 fits in the row bytes.
module nps_row_addr #(
    parameter int BLK_W    = 12,
    parameter int PAGE_W   = 6,
    parameter int PPB_LOG2 = 6,
    parameter int SEL_W    = 2
) (
    input  logic [BLK_W-1:0]  block_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic [SEL_W-1:0]  sel_i,
    output logic [7:0]        byte_o
);
    import nps_pkg::*;

    localparam int ROW_W = 8 * ROW_BYTES;
    localparam int SLOTS = 1 << SEL_W;

    logic [ROW_W-1:0] row;
    logic [7:0]       slot [SLOTS];

    assign row = (ROW_W'(block_i) << PPB_LOG2) + ROW_W'(page_i);

    for (genvar g = 0; g < SLOTS; g++) begin : g_slot
        if (g < ROW_BYTES) begin : g_used
            assign slot[g] = row[8*g +: 8];
        end else begin : g_pad
            assign slot[g] = 8'h00;
        end
    end

    assign byte_o = slot[sel_i];
endmodule

// File: rtl/nand_prog_seq.sv
// NAND page program sequencer: runs setup command, column and row
// address, main and spare data, confirm, busy wait and status polling
// for one page, then reports pass, fail or timeout.
// Assumes PAGE_BYTES >= 1 and SPARE_BYTES >= 1; bus outputs are decoded
// from the registered state, and the stream byte goes to the bus in
// the cycle it is accepted.
module nand_prog_seq #(
    parameter int PAGE_BYTES  = 2048,
    parameter int SPARE_BYTES = 64,
    parameter int BLK_W       = 12,
    parameter int PAGE_W      = 6,
    parameter int PPB_LOG2    = 6,
    parameter int TMO_W       = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  block_i,
    input  logic [PAGE_W-1:0] page_i,
    input  logic              five_cyc_i,
    input  logic              multi_plane_i,
    input  logic [TMO_W-1:0]  timeout_i,
    input  logic              s_valid,
    input  logic [7:0]        s_data,
    output logic              s_ready,
    output logic              nf_ce_n,
    output logic              nf_cle,
    output logic              nf_ale,
    output logic              nf_wr,
    output logic              nf_rd,
    output logic [7:0]        nf_dq_o,
    input  logic [7:0]        nf_dq_i,
    input  logic              nf_rb,
    output logic              ecc_en,
    output logic              done,
    output logic              err_fail,
    output logic              err_tmo
);
    import nps_pkg::*;

    localparam int CNT_W = $clog2(PAGE_BYTES + SPARE_BYTES + 1);
    localparam int SEL_W = 2;
    localparam logic [CNT_W-1:0] MAIN_LAST  = CNT_W'(PAGE_BYTES - 1);
    localparam logic [CNT_W-1:0] SPARE_LAST = CNT_W'(SPARE_BYTES - 1);
    localparam logic [SEL_W-1:0] ROW_LAST   = SEL_W'(ROW_BYTES - 1);

    nps_state_e        state_q;
    logic [BLK_W-1:0]  blk_q;
    logic [PAGE_W-1:0] page_q;
    logic              five_q;
    logic              mp_q;
    logic [TMO_W-1:0]  tmo_q;
    logic [SEL_W-1:0]  idx_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              fail_q;
    logic              tmo_err_q;

    logic [7:0]        row_byte;
    logic              rb_done;
    logic              tmr_expired;

    nps_row_addr #(
        .BLK_W    (BLK_W),
        .PAGE_W   (PAGE_W),
        .PPB_LOG2 (PPB_LOG2),
        .SEL_W    (SEL_W)
    ) u_row (
        .block_i (blk_q),
        .page_i  (page_q),
        .sel_i   (idx_q),
        .byte_o  (row_byte)
    );

    nps_rb_sync u_rb (
        .clk    (clk),
        .rst_n  (rst_n),
        .rb_i   (nf_rb),
        .arm_i  (state_q == ST_CONF),
        .done_o (rb_done)
    );

    nps_busy_timer #(
        .W (TMO_W)
    ) u_tmr (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr_i     (state_q == ST_CONF),
        .run_i     (state_q == ST_WAIT),
        .limit_i   (tmo_q),
        .expired_o (tmr_expired)
    );

    // sequence control: state, byte counters, captured request, result flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q   <= ST_IDLE;
            blk_q     <= '0;
            page_q    <= '0;
            five_q    <= 1'b0;
            mp_q      <= 1'b0;
            tmo_q     <= '0;
            idx_q     <= '0;
            cnt_q     <= '0;
            fail_q    <= 1'b0;
            tmo_err_q <= 1'b0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        blk_q     <= block_i;
                        page_q    <= page_i;
                        five_q    <= five_cyc_i;
                        mp_q      <= multi_plane_i;
                        tmo_q     <= timeout_i;
                        fail_q    <= 1'b0;
                        tmo_err_q <= 1'b0;
                        state_q   <= ST_SETUP;
                    end
                end
                ST_SETUP: begin
                    idx_q   <= '0;
                    state_q <= ST_COL;
                end
                ST_COL: begin
                    if (idx_q == (five_q ? SEL_W'(1) : SEL_W'(0))) begin
                        idx_q   <= '0;
                        state_q <= ST_ROW;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_ROW: begin
                    if (idx_q == ROW_LAST) begin
                        cnt_q   <= '0;
                        state_q <= ST_MAIN;
                    end else begin
                        idx_q <= idx_q + 1'b1;
                    end
                end
                ST_MAIN: begin
                    if (s_valid) begin
                        if (cnt_q == MAIN_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_SPARE;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_SPARE: begin
                    if (s_valid) begin
                        if (cnt_q == SPARE_LAST) begin
                            cnt_q   <= '0;
                            state_q <= ST_CONF;
                        end else begin
                            cnt_q <= cnt_q + 1'b1;
                        end
                    end
                end
                ST_CONF: state_q <= ST_WAIT;
                ST_WAIT: begin
                    if (rb_done) begin
                        state_q <= ST_STAT;
                    end else if (tmr_expired) begin
                        tmo_err_q <= 1'b1;
                        state_q   <= ST_END;
                    end
                end
                ST_STAT: state_q <= ST_POLL;
                ST_POLL: begin
                    if (nf_dq_i[STAT_RDY_BIT]) begin
                        fail_q  <= nf_dq_i[STAT_FAIL_BIT];
                        state_q <= ST_END;
                    end
                end
                ST_END:  state_q <= ST_IDLE;
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // bus strobes, data byte and stream handshake decoded from the state
    always_comb begin
        nf_cle  = 1'b0;
        nf_ale  = 1'b0;
        nf_wr   = 1'b0;
        nf_rd   = 1'b0;
        nf_dq_o = 8'h00;
        s_ready = 1'b0;
        ecc_en  = 1'b0;
        case (state_q)
            ST_SETUP: begin
                nf_cle  = 1'b1;
                nf_wr   = 1'b1;
                nf_dq_o = CMD_PROG_SETUP;
            end
            ST_COL: begin
                nf_ale = 1'b1;
                nf_wr  = 1'b1;
            end
            ST_ROW: begin
                nf_ale  = 1'b1;
                nf_wr   = 1'b1;
                nf_dq_o = row_byte;
            end
            ST_MAIN: begin
                s_ready = 1'b1;
                ecc_en  = 1'b1;
                nf_wr   = s_valid;
                nf_dq_o = s_data;
            end
            ST_SPARE: begin
                s_ready = 1'b1;
                nf_wr   = s_valid;
                nf_dq_o = s_data;
            end
            ST_CONF: begin
                nf_cle  = 1'b1;
                nf_wr   = 1'b1;
                nf_dq_o = CMD_PROG_CONF;
            end
            ST_STAT: begin
                nf_cle  = 1'b1;
                nf_wr   = 1'b1;
                nf_dq_o = mp_q ? CMD_STATUS_MP : CMD_STATUS;
            end
            ST_POLL: nf_rd = 1'b1;
            default: ;
        endcase
    end

    assign nf_ce_n  = (state_q == ST_IDLE) || (state_q == ST_END);
    assign done     = (state_q == ST_END);
    assign err_fail = fail_q;
    assign err_tmo  = tmo_err_q;
endmodule

// File: rtl/nand_prog_seq_chk.sv
// Property checker for the page program sequencer, attached by bind.
// Observes only top-level ports.
module nand_prog_seq_chk (
    input logic clk,
    input logic rst_n,
    input logic start,
    input logic s_ready,
    input logic nf_ce_n,
    input logic nf_cle,
    input logic nf_ale,
    input logic nf_wr,
    input logic nf_rd,
    input logic ecc_en,
    input logic done,
    input logic err_fail,
    input logic err_tmo
);
    // R1: chip enable is asserted on every bus write
    p_wr_under_ce_r1: assert property (@(posedge clk) disable iff (!rst_n)
        nf_wr |-> !nf_ce_n);

    // R1: a byte is never tagged as both command and address
    p_cle_ale_excl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_cle && nf_ale));

    // R4: the stream is accepted only while data bytes are moved
    p_ready_data_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
        s_ready |-> (!nf_cle && !nf_ale && !nf_rd));

    // R5: the ECC window never covers a command or address byte
    p_ecc_no_ctl_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ecc_en |-> (s_ready && !nf_cle && !nf_ale));

    // R8: reads and writes never share a cycle
    p_rd_wr_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(nf_rd && nf_wr));

    // R9: timeout and fail are not reported together
    p_err_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(err_fail && err_tmo));

    // R10: completion pulse lasts one cycle
    p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R10: chip enable is released by the time done is shown
    p_done_ce_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> nf_ce_n);

    // R10: result flags change only at completion or after a start
    p_flags_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !start |=> ($stable({err_fail, err_tmo}) || done));
endmodule

bind nand_prog_seq nand_prog_seq_chk u_chk (.*);

// File: tb/nand_prog_seq_tb.sv
// Bench for the page program sequencer: a flash model, a stream source,
// directed corner cases and seeded random operations.
module nand_prog_seq_tb;
    localparam int PB     = 16;
    localparam int SB     = 4;
    localparam int BLK_W  = 10;
    localparam int PAGE_W = 5;
    localparam int L2     = 5;
    localparam int TMO_W  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start = 1'b0;
    logic [BLK_W-1:0]  block_i = '0;
    logic [PAGE_W-1:0] page_i = '0;
    logic              five_cyc_i = 1'b0;
    logic              multi_plane_i = 1'b0;
    logic [TMO_W-1:0]  timeout_i = '0;
    logic              s_valid = 1'b0;
    logic [7:0]        s_data = 8'h00;
    logic              s_ready;
    logic              nf_ce_n, nf_cle, nf_ale, nf_wr, nf_rd;
    logic [7:0]        nf_dq_o;
    logic [7:0]        nf_dq_i;
    logic              nf_rb = 1'b1;
    logic              ecc_en, done, err_fail, err_tmo;

    always #2.5 clk = ~clk;

    nand_prog_seq #(
        .PAGE_BYTES (PB), .SPARE_BYTES (SB), .BLK_W (BLK_W),
        .PAGE_W (PAGE_W), .PPB_LOG2 (L2), .TMO_W (TMO_W)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start (start), .block_i (block_i),
        .page_i (page_i), .five_cyc_i (five_cyc_i),
        .multi_plane_i (multi_plane_i), .timeout_i (timeout_i),
        .s_valid (s_valid), .s_data (s_data), .s_ready (s_ready),
        .nf_ce_n (nf_ce_n), .nf_cle (nf_cle), .nf_ale (nf_ale),
        .nf_wr (nf_wr), .nf_rd (nf_rd), .nf_dq_o (nf_dq_o),
        .nf_dq_i (nf_dq_i), .nf_rb (nf_rb), .ecc_en (ecc_en),
        .done (done), .err_fail (err_fail), .err_tmo (err_tmo)
    );

    int total = 0;
    int bad = 0;

    // model configuration, set by the test tasks between operations
    logic       clr_log = 1'b0;
    logic       src_en = 1'b0;
    int         m_poll_busy = 0;
    logic       m_fail = 1'b0;
    int         m_rb_delay = 2;
    int         m_rb_low = 5;
    logic       m_no_low = 1'b0;
    logic       m_stuck = 1'b0;
    logic [7:0] data_b [0:63];

    // recorded activity
    logic [10:0] lg [0:127];
    int          lg_n = 0;
    int          cyc = 0;
    int          conf_cyc = 0, stat_cyc = 0, rise_cyc = 0, done_cyc = 0;
    int          done_cnt = 0, rd_cnt = 0, rbc = 0, src_i = 0;

    // status byte: not ready with a stray bit 0 until the busy count is used up
    assign nf_dq_i = (rd_cnt < m_poll_busy) ? 8'h01 : {1'b0, 1'b1, 5'b0, m_fail};

    // bus logger, flash ready/busy model and stream source
    always @(posedge clk) begin
        int nxt;
        cyc <= cyc + 1;
        if (clr_log) begin
            lg_n <= 0; done_cnt <= 0; rd_cnt <= 0; rbc <= 0; nf_rb <= 1'b1;
            src_i <= 0; s_valid <= 1'b0; s_data <= data_b[0];
            conf_cyc <= 0; stat_cyc <= 0; rise_cyc <= 0; done_cyc <= 0;
        end else begin
            if (nf_wr && lg_n < 128) begin
                lg[lg_n] <= {ecc_en, nf_cle, nf_ale, nf_dq_o};
                lg_n <= lg_n + 1;
            end
            if (nf_wr && nf_cle && nf_dq_o == 8'h10) conf_cyc <= cyc;
            if (nf_wr && nf_cle && (nf_dq_o == 8'h70 || nf_dq_o == 8'h71)) stat_cyc <= cyc;
            if (done) begin done_cnt <= done_cnt + 1; done_cyc <= cyc; end
            if (nf_rd) rd_cnt <= rd_cnt + 1;
            if (nf_wr && nf_cle && nf_dq_o == 8'h10) rbc <= 1;
            else if (rbc != 0) begin
                rbc <= rbc + 1;
                if (rbc == m_rb_delay && !m_no_low) nf_rb <= 1'b0;
                if (rbc == m_rb_delay + m_rb_low && !m_stuck && !m_no_low) begin
                    nf_rb <= 1'b1; rise_cyc <= cyc; rbc <= 0;
                end
            end
            nxt = (s_valid && s_ready) ? src_i + 1 : src_i;
            src_i <= nxt;
            s_data <= data_b[nxt[5:0]];
            s_valid <= src_en && ($urandom % 4 != 0);
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [23:0] row_of(input int blk, input int pg);
        return 24'((blk << L2) + pg);
    endfunction

    function automatic string tag_of(input int i, input int ncol);
        if (i == 0) return "R1";
        if (i <= ncol) return "R2";
        if (i <= ncol + 3) return "R3";
        if (i <= ncol + 3 + PB + SB) return "R4";
        if (i == ncol + 4 + PB + SB) return "R6";
        return "R7";
    endfunction

    task automatic run_op(input int blk, input int pg, input bit five, input bit mp,
                          input bit fail, input int pollb, input int dly, input int low,
                          input bit nolow, input bit stuck, input int tmo, input bit mid);
        logic [10:0] e [0:127];
        int n = 0;
        int ncol = five ? 2 : 1;
        logic [23:0] row = row_of(blk, pg);
        bit exp_tmo = nolow || stuck;
        int w = 0;
        @(negedge clk);
        for (int i = 0; i < 64; i++) data_b[i] = 8'($urandom);
        m_poll_busy = pollb; m_fail = fail; m_rb_delay = dly; m_rb_low = low;
        m_no_low = nolow; m_stuck = stuck;
        clr_log = 1'b1;
        @(negedge clk);
        clr_log = 1'b0; src_en = 1'b1;
        block_i = BLK_W'(blk); page_i = PAGE_W'(pg); five_cyc_i = five;
        multi_plane_i = mp; timeout_i = TMO_W'(tmo); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        chk(err_fail == 0 && err_tmo == 0, "R10 flags cleared by start",
            {err_fail, err_tmo}, 0);
        chk(nf_ce_n == 0, "R1 ce low during op", nf_ce_n, 0);
        if (mid) begin
            // R11: a second start and new block/page while running
            repeat (3) @(negedge clk);
            block_i = ~block_i; page_i = ~page_i; start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (done_cnt == 0 && w < 3000) begin @(negedge clk); w++; end
        chk(w < 3000, "watchdog", w, 3000);
        src_en = 1'b0;
        repeat (4) @(negedge clk);
        // expected bus log
        e[n++] = {3'b010, 8'h80};
        for (int i = 0; i < ncol; i++) e[n++] = {3'b001, 8'h00};
        for (int i = 0; i < 3; i++) e[n++] = {3'b001, row[8*i +: 8]};
        for (int i = 0; i < PB; i++) e[n++] = {3'b100, data_b[i]};
        for (int i = 0; i < SB; i++) e[n++] = {3'b000, data_b[PB+i]};
        e[n++] = {3'b010, 8'h10};
        if (!exp_tmo) e[n++] = {3'b010, mp ? 8'h71 : 8'h70};
        chk(lg_n == n, "R4/R11 write count", lg_n, n);
        for (int i = 0; i < n && i < lg_n; i++) begin
            chk(lg[i][9:0] == e[i][9:0], tag_of(i, ncol), int'(lg[i][9:0]), int'(e[i][9:0]));
            chk(lg[i][10] == e[i][10], "R5 ecc window", lg[i][10], e[i][10]);
        end
        chk(done_cnt == 1, "R10 single done", done_cnt, 1);
        chk(nf_ce_n == 1, "R10 ce released", nf_ce_n, 1);
        chk(err_tmo == exp_tmo, "R9 timeout flag", err_tmo, exp_tmo);
        chk(err_fail == (fail && !exp_tmo), "R8 fail flag", err_fail, fail && !exp_tmo);
        if (exp_tmo) begin
            chk(done_cyc - conf_cyc == tmo + 2, "R9 timeout cycle", done_cyc - conf_cyc, tmo + 2);
            chk(rd_cnt == 0, "R9 no status read", rd_cnt, 0);
        end else begin
            chk(stat_cyc - rise_cyc == 4, "R7 status after rb rise", stat_cyc - rise_cyc, 4);
            chk(rd_cnt == pollb + 1, "R8 poll count", rd_cnt, pollb + 1);
        end
        repeat (6) @(negedge clk);
        chk(err_tmo == exp_tmo && err_fail == (fail && !exp_tmo), "R10 flags held",
            {err_fail, err_tmo}, {fail && !exp_tmo, exp_tmo});
    endtask

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 64; i++) data_b[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(nf_ce_n == 1 && done == 0 && s_ready == 0 && nf_wr == 0 && nf_rd == 0,
            "R1 reset state", {nf_ce_n, done, s_ready, nf_wr, nf_rd}, 5'b10000);
        chk(err_fail == 0 && err_tmo == 0, "R10 reset flags", {err_fail, err_tmo}, 0);
        // directed: 4-cycle address, pass, immediate ready status
        run_op(3, 7, 0, 0, 0, 0, 2, 5, 0, 0, 200, 0);
        // directed: 5-cycle address, multi-plane, fail with busy polls, mid start
        run_op(1023, 31, 1, 1, 1, 3, 4, 8, 0, 0, 200, 1);
        // directed: flash stays busy -> timeout
        run_op(5, 0, 0, 0, 1, 0, 2, 5, 0, 1, 40, 0);
        // directed: flash never goes busy -> timeout, limit zero edge
        run_op(0, 1, 1, 0, 0, 0, 2, 5, 1, 0, 0, 0);
        // pass after a timeout clears the flag
        run_op(512, 16, 0, 1, 0, 1, 3, 3, 0, 0, 100, 0);
        // seeded random operations
        for (int k = 0; k < 6; k++) begin
            run_op(int'($urandom % 1024), int'($urandom % 32), 1'($urandom), 1'($urandom),
                   1'($urandom), int'($urandom % 5), 1 + int'($urandom % 6),
                   3 + int'($urandom % 10), 0, 0, 300, 1'($urandom));
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // global guard against a hung run
    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog act=%0d exp=%0d", 190000, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule